// File: doc/BRIEF.md
# Two-Step Qualified Pattern Trigger

This block watches a 28-bit sampled logic bus and fires when two patterns appear one after the other. Each step is described by a pair of words. The data word gives the level each pin must have. The care word selects which pins take part in the comparison; a pin whose care bit is 0 is a don't-care. The first pair is compared on every enabled sample. The second pair is only compared once the first pattern has been seen. When the second pattern then appears, the block raises a one-cycle trigger pulse.

The comparator only looks at the bus while the bus enable input is high. Two sticky flags report progress: one says that step one has been seen, the other that step two has been seen. The arm input clears both flags and restarts the sequence. The words are expected to be held stable by the surrounding logic while the block is watching. All outputs are registered and change on the clock edge that samples the qualifying inputs.

Top module: `seq_trigger`

## Requirements
- R1: While rst_n is low, and on the first sample after it is released, step1_seen, step2_seen and trig_pulse are all 0.
- R2: When bus_en is high and every bit position where w1_care is 1 has bus_in equal to w1_data, step1_seen is 1 after that clock edge. Bits where w1_care is 0 do not take part in the comparison.
- R3: A mismatch on any single cared bit prevents that step from matching on that sample.
- R4: The second word is not compared before step1_seen is 1. A sample that matches both words while step1_seen is 0 sets only step1_seen.
- R5: When step1_seen is 1, step2_seen is 0, bus_en is high and the bus matches the second word under w2_care, trig_pulse is 1 for exactly one cycle and step2_seen becomes 1 and stays 1.
- R6: While bus_en is low and arm is low, both flags keep their value and trig_pulse stays 0, whatever bus_in carries.
- R7: arm high clears step1_seen, step2_seen and trig_pulse on the next edge. It takes priority over any match on the same sample and works whether bus_en is high or low.
- R8: A first-word match while step1_seen is already 1 changes nothing. A second-word match after step2_seen is already 1 gives no further pulse.
- R9: A care word of all zeros matches any bus value on an enabled sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | WIDTH | Sampled bus being watched |
| bus_en | input | 1 | Lets the bus reach the comparators |
| w1_data | input | WIDTH | Required levels for step one |
| w1_care | input | WIDTH | 1 = compare this pin for step one |
| w2_data | input | WIDTH | Required levels for step two |
| w2_care | input | WIDTH | 1 = compare this pin for step two |
| arm | input | 1 | Clears progress and restarts the sequence |
| step1_seen | output | 1 | Sticky: step one has matched |
| step2_seen | output | 1 | Sticky: step two has matched |
| trig_pulse | output | 1 | One-cycle pulse when step two matches |

## Verification
The bench applies four kinds of samples. A sample that differs from the first word only on don't-care pins shows that masking works. A sample with one cared bit flipped shows that a single-bit miss blocks a step. A sample that matches both words at once, taken from the cleared state, separates a correct block from one that arms the second word too early. The second word is then offered with bus_en low, with arm high, and again after completion. These cases show the gating by the enable, the priority of arm, and that the pulse fires only once. A final pass with all-zero care words shows that an empty qualifier matches any bus.

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_in,
  input  logic             bus_en,
  input  logic [WIDTH-1:0] w1_data,
  input  logic [WIDTH-1:0] w1_care,
  input  logic [WIDTH-1:0] w2_data,
  input  logic [WIDTH-1:0] w2_care,
  input  logic             arm,
  output logic             step1_seen,
  output logic             step2_seen,
  output logic             trig_pulse
);

  logic hit1, hit2, fire;

  assign hit1 = bus_en && (((bus_in ^ w1_data) & w1_care) == '0);
  assign hit2 = bus_en && (((bus_in ^ w2_data) & w2_care) == '0);
  assign fire = step1_seen && !step2_seen && hit2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step1_seen <= 1'b0;
      step2_seen <= 1'b0;
      trig_pulse <= 1'b0;
    end else if (arm) begin
      step1_seen <= 1'b0;
      step2_seen <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      if (hit1) step1_seen <= 1'b1;
      if (fire) step2_seen <= 1'b1;
      trig_pulse <= fire;
    end
  end

endmodule

module seq_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_en,
  input logic arm,
  input logic step1_seen,
  input logic step2_seen,
  input logic trig_pulse
);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  assert_pulse_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> step2_seen);

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step2_seen) |-> $past(step1_seen));

  assert_flag_nesting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step2_seen |-> step1_seen);

  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!step1_seen && !step2_seen && !trig_pulse));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en && !arm) |=> ($stable(step1_seen) && $stable(step2_seen) && !trig_pulse));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step2_seen && !arm) |=> (step2_seen && !trig_pulse));

endmodule

bind seq_trigger seq_trigger_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .arm        (arm),
  .step1_seen (step1_seen),
  .step2_seen (step2_seen),
  .trig_pulse (trig_pulse)
);

// File: tb/tb_seq_trigger.sv
module tb_seq_trigger;
  localparam int W = 28;
  localparam logic [W-1:0] D1 = 28'h0F0F0F0;
  localparam logic [W-1:0] Q1 = 28'h0FFFF00;
  localparam logic [W-1:0] D2 = 28'h9F0F0C3;
  localparam logic [W-1:0] Q2 = 28'hFFFFFFF;
  localparam int N = 12;
  // {arm, en, bus, exp step1, exp step2, exp pulse}
  localparam logic [32:0] TBL [0:N-1] = '{
    {1'b1, 1'b1, 28'h0000000,           3'b000},  // R7
    {1'b0, 1'b1, D1 ^ 28'h0000100,      3'b000},  // R3
    {1'b0, 1'b1, D1 ^ 28'hF0000FF,      3'b100},  // R2
    {1'b0, 1'b1, D1,                    3'b100},  // R8
    {1'b0, 1'b0, D2,                    3'b100},  // R6
    {1'b0, 1'b1, D2 ^ 28'h0000001,      3'b100},  // R3
    {1'b0, 1'b1, D2,                    3'b111},  // R5
    {1'b0, 1'b1, D2,                    3'b110},  // R5 R8
    {1'b1, 1'b1, D2,                    3'b000},  // R7
    {1'b0, 1'b1, D2,                    3'b100},  // R4
    {1'b0, 1'b1, D2,                    3'b111},  // R5
    {1'b1, 1'b0, D2,                    3'b000}   // R7
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, arm = 1'b0;
  logic [W-1:0] bus_in = '0, w1_data = D1, w1_care = Q1, w2_data = D2, w2_care = Q2;
  logic step1_seen, step2_seen, trig_pulse;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seq_trigger #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_en(bus_en),
    .w1_data(w1_data), .w1_care(w1_care), .w2_data(w2_data), .w2_care(w2_care),
    .arm(arm), .step1_seen(step1_seen), .step2_seen(step2_seen), .trig_pulse(trig_pulse)
  );

  task automatic check(input string req, input logic [2:0] exp);
    applied++;
    if ({step1_seen, step2_seen, trig_pulse} !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req,
               {step1_seen, step2_seen, trig_pulse}, exp);
    end
  endtask

  task automatic step(input logic a, input logic e, input logic [W-1:0] b);
    @(negedge clk);
    arm = a; bus_en = e; bus_in = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 3'b000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after release", 3'b000);

    for (int i = 0; i < N; i++) begin
      step(TBL[i][32], TBL[i][31], TBL[i][30:3]);
      check($sformatf("R2-table row %0d", i), TBL[i][2:0]);
    end

    w1_care = '0; w2_care = '0;
    step(1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 28'h5A5A5A5);
    check("R9 empty care word one", 3'b100);
    step(1'b0, 1'b1, 28'hA5A5A5A);
    check("R9 empty care word two", 3'b111);

    step(1'b0, 1'b1, 28'h0);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 mid-run reset", 3'b000);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule